// File: doc/BRIEF.md
# Common Bus Register Datapath

This block is the register and memory datapath of a small accumulator machine. Six working registers and a word-addressed memory all exchange data over a single shared bus. A 3-bit select code names the one source that drives the bus in a given cycle. Any register whose load strobe is high captures the bus on the next rising clock edge. The memory is addressed only by the address register, so every memory access begins by placing its address there.

Every register has its own clear, load and increment strobes. It keeps its value in any cycle where none of them is high. The accumulator can also take the bitwise AND of itself and the data register. Sequencing is not part of this block: an external controller drives every strobe and the select code as plain inputs each cycle, and reads the registers and the bus through the outputs.

The registers are: address register (12 bits), program counter (12 bits), data register, accumulator, instruction register and temporary register (each 16 bits). The memory holds 4096 words of 16 bits.

Top module: `bus_datapath`

## Requirements
- R1: While `rst_n` is low, every register is cleared to zero on each clock edge. With select 000 the bus reads zero.
- R2: The bus carries the source chosen by `bus_sel`: 000 zero, 001 address register, 010 program counter, 011 data register, 100 accumulator, 101 instruction register, 110 temporary register, 111 memory word at the address register. A 12-bit source drives the bus with bits 15..12 at zero.
- R3: When `mem_wr` is high, the bus value is written into the memory word at the address register on that clock edge. Select 111 then shows the stored word combinationally in the same cycle it is selected.
- R4: A load strobe makes its register take the bus value on the next edge. The 12-bit registers take bus bits 11..0.
- R5: A register with none of its strobes high keeps its value across a clock edge.
- R6: When `ac_and` is high and neither accumulator clear nor accumulator load is high, the accumulator becomes the bitwise AND of the accumulator and the data register on the next edge.
- R7: An increment strobe adds one to its register on the next edge, wrapping to zero at the register's width (0xFFF for the 12-bit registers, 0xFFFF for the 16-bit ones).
- R8: Priority per register is clear over load over increment. For the accumulator the order is clear, load, AND, increment.
- R9: The memory read value depends only on the address register. Changing the program counter or other registers does not alter what select 111 puts on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 3 | Bus source select code |
| ar_ld | input | 1 | Address register load from bus |
| ar_inr | input | 1 | Address register increment |
| ar_clr | input | 1 | Address register clear |
| pc_ld | input | 1 | Program counter load from bus |
| pc_inr | input | 1 | Program counter increment |
| pc_clr | input | 1 | Program counter clear |
| dr_ld | input | 1 | Data register load from bus |
| dr_inr | input | 1 | Data register increment |
| dr_clr | input | 1 | Data register clear |
| ac_ld | input | 1 | Accumulator load from bus |
| ac_inr | input | 1 | Accumulator increment |
| ac_clr | input | 1 | Accumulator clear |
| ac_and | input | 1 | Accumulator AND with data register |
| ir_ld | input | 1 | Instruction register load from bus |
| ir_inr | input | 1 | Instruction register increment |
| ir_clr | input | 1 | Instruction register clear |
| tr_ld | input | 1 | Temporary register load from bus |
| tr_inr | input | 1 | Temporary register increment |
| tr_clr | input | 1 | Temporary register clear |
| mem_wr | input | 1 | Write bus value to memory at address register |
| bus | output | 16 | Current bus value |
| ar_q | output | 12 | Address register |
| pc_q | output | 12 | Program counter |
| dr_q | output | 16 | Data register |
| ac_q | output | 16 | Accumulator |
| ir_q | output | 16 | Instruction register |
| tr_q | output | 16 | Temporary register |

## Verification
The bus is combinational, so a select change, including a memory read with select 111, is due in the same cycle. Register updates and memory writes are due one clock edge after the strobe. A written word is therefore readable from the following cycle. The bench changes inputs on the falling edge. It checks the bus a short delay after driving the select, and it checks registers at the falling edge that follows the rising edge on which they update. No result is sampled at the edge where it changes.

// File: rtl/bus_datapath.sv
module bus_datapath #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        bus_sel,
  input  logic              ar_ld,
  input  logic              ar_inr,
  input  logic              ar_clr,
  input  logic              pc_ld,
  input  logic              pc_inr,
  input  logic              pc_clr,
  input  logic              dr_ld,
  input  logic              dr_inr,
  input  logic              dr_clr,
  input  logic              ac_ld,
  input  logic              ac_inr,
  input  logic              ac_clr,
  input  logic              ac_and,
  input  logic              ir_ld,
  input  logic              ir_inr,
  input  logic              ir_clr,
  input  logic              tr_ld,
  input  logic              tr_inr,
  input  logic              tr_clr,
  input  logic              mem_wr,
  output logic [DATA_W-1:0] bus,
  output logic [ADDR_W-1:0] ar_q,
  output logic [ADDR_W-1:0] pc_q,
  output logic [DATA_W-1:0] dr_q,
  output logic [DATA_W-1:0] ac_q,
  output logic [DATA_W-1:0] ir_q,
  output logic [DATA_W-1:0] tr_q
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAD   = DATA_W - ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rd_word;

  assign rd_word = mem[ar_q];

  always_comb begin
    case (bus_sel)
      3'd1:    bus = {{PAD{1'b0}}, ar_q};
      3'd2:    bus = {{PAD{1'b0}}, pc_q};
      3'd3:    bus = dr_q;
      3'd4:    bus = ac_q;
      3'd5:    bus = ir_q;
      3'd6:    bus = tr_q;
      3'd7:    bus = rd_word;
      default: bus = '0;
    endcase
  end

  always_ff @(posedge clk)
    if (mem_wr) mem[ar_q] <= bus;

  always_ff @(posedge clk)
    if (!rst_n || ar_clr) ar_q <= '0;
    else if (ar_ld)       ar_q <= bus[ADDR_W-1:0];
    else if (ar_inr)      ar_q <= ar_q + 1'b1;

  always_ff @(posedge clk)
    if (!rst_n || pc_clr) pc_q <= '0;
    else if (pc_ld)       pc_q <= bus[ADDR_W-1:0];
    else if (pc_inr)      pc_q <= pc_q + 1'b1;

  always_ff @(posedge clk)
    if (!rst_n || dr_clr) dr_q <= '0;
    else if (dr_ld)       dr_q <= bus;
    else if (dr_inr)      dr_q <= dr_q + 1'b1;

  always_ff @(posedge clk)
    if (!rst_n || ac_clr) ac_q <= '0;
    else if (ac_ld)       ac_q <= bus;
    else if (ac_and)      ac_q <= ac_q & dr_q;
    else if (ac_inr)      ac_q <= ac_q + 1'b1;

  always_ff @(posedge clk)
    if (!rst_n || ir_clr) ir_q <= '0;
    else if (ir_ld)       ir_q <= bus;
    else if (ir_inr)      ir_q <= ir_q + 1'b1;

  always_ff @(posedge clk)
    if (!rst_n || tr_clr) tr_q <= '0;
    else if (tr_ld)       tr_q <= bus;
    else if (tr_inr)      tr_q <= tr_q + 1'b1;

  AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !pc_ld && !pc_inr && !pc_clr |=> $stable(pc_q)); // R5
  AST_AC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ac_ld && !ac_inr && !ac_clr && !ac_and |=> $stable(ac_q)); // R5
  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    pc_inr && !pc_ld && !pc_clr |=> pc_q == $past(pc_q) + 1'b1); // R7
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    pc_ld && pc_inr && !pc_clr |=> pc_q == $past(bus[ADDR_W-1:0])); // R8
  AST_AC_AND: assert property (@(posedge clk) disable iff (!rst_n)
    ac_and && !ac_ld && !ac_clr |=> ac_q == ($past(ac_q) & $past(dr_q))); // R6
  AST_AC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ac_clr |=> ac_q == '0); // R8
  AST_MEM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr && !ar_ld && !ar_inr && !ar_clr |=> bus_sel != 3'd7 || bus == $past(bus)); // R3
  AST_READ_BY_AR: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel == 3'd7 && !mem_wr && !ar_ld && !ar_inr && !ar_clr |=> bus_sel != 3'd7 || $stable(bus)); // R9
endmodule

// File: tb/bus_datapath_tb_top.sv
`timescale 1ns/1ps
module bus_datapath_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  logic [2:0] bus_sel;
  logic ar_ld, ar_inr, ar_clr, pc_ld, pc_inr, pc_clr, dr_ld, dr_inr, dr_clr;
  logic ac_ld, ac_inr, ac_clr, ac_and, ir_ld, ir_inr, ir_clr;
  logic tr_ld, tr_inr, tr_clr, mem_wr;
  logic [15:0] bus, dr_q, ac_q, ir_q, tr_q;
  logic [11:0] ar_q, pc_q;

  int checks = 0;
  int fails  = 0;
  logic [15:0] exp_mem [64];
  logic [15:0] exp_ac;

  always #5 clk = ~clk;

  bus_datapath dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel),
    .ar_ld(ar_ld), .ar_inr(ar_inr), .ar_clr(ar_clr),
    .pc_ld(pc_ld), .pc_inr(pc_inr), .pc_clr(pc_clr),
    .dr_ld(dr_ld), .dr_inr(dr_inr), .dr_clr(dr_clr),
    .ac_ld(ac_ld), .ac_inr(ac_inr), .ac_clr(ac_clr), .ac_and(ac_and),
    .ir_ld(ir_ld), .ir_inr(ir_inr), .ir_clr(ir_clr),
    .tr_ld(tr_ld), .tr_inr(tr_inr), .tr_clr(tr_clr),
    .mem_wr(mem_wr), .bus(bus),
    .ar_q(ar_q), .pc_q(pc_q), .dr_q(dr_q), .ac_q(ac_q), .ir_q(ir_q), .tr_q(tr_q)
  );

  task automatic idle();
    bus_sel = 3'd0;
    {ar_ld, ar_inr, ar_clr, pc_ld, pc_inr, pc_clr, dr_ld, dr_inr, dr_clr} = '0;
    {ac_ld, ac_inr, ac_clr, ac_and, ir_ld, ir_inr, ir_clr} = '0;
    {tr_ld, tr_inr, tr_clr, mem_wr} = '0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] h_ar, h_pc, h_dr, h_ac, h_ir, h_tr;
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 ar", {4'h0, ar_q}, 16'h0);
    chk("R1 pc", {4'h0, pc_q}, 16'h0);
    chk("R1 dr", dr_q, 16'h0);
    chk("R1 ac", ac_q, 16'h0);
    chk("R1 ir", ir_q, 16'h0);
    chk("R1 tr", tr_q, 16'h0);
    for (int s = 0; s < 7; s++) begin
      bus_sel = 3'(s);
      #1 chk("R2 bus after reset", bus, 16'h0);
    end
    idle();

    ac_inr = 1'b1;
    repeat (65535) @(posedge clk);
    @(negedge clk); idle();
    chk("R7 ac count", ac_q, 16'hFFFF);

    bus_sel = 3'd4; ar_ld = 1'b1; tick();
    chk("R4 ar takes low bits", {4'h0, ar_q}, 16'h0FFF);
    bus_sel = 3'd1;
    #1 chk("R2 ar zero-extended", bus, 16'h0FFF);
    idle();

    bus_sel = 3'd4; tr_ld = 1'b1; tick();
    chk("R4 tr load", tr_q, 16'hFFFF);
    bus_sel = 3'd6;
    #1 chk("R2 tr on bus", bus, 16'hFFFF);
    idle();
    tr_inr = 1'b1; tick();
    chk("R7 tr wrap", tr_q, 16'h0);

    ar_inr = 1'b1; tick();
    chk("R7 ar wrap", {4'h0, ar_q}, 16'h0);

    pc_inr = 1'b1;
    repeat (7) @(posedge clk);
    @(negedge clk); idle();
    chk("R7 pc count", {4'h0, pc_q}, 16'd7);
    bus_sel = 3'd2;
    #1 chk("R2 pc on bus", bus, 16'd7);
    idle();

    for (int i = 0; i < 64; i++) begin
      bus_sel = 3'd2; mem_wr = 1'b1; ar_inr = 1'b1; pc_inr = 1'b1; tick();
      pc_inr = 1'b1; tick();
      exp_mem[i] = 16'(7 + 2 * i);
    end
    chk("R7 ar after sweep", {4'h0, ar_q}, 16'd64);
    chk("R7 pc after sweep", {4'h0, pc_q}, 16'd135);

    ar_clr = 1'b1; tick();
    chk("R8 ar clear", {4'h0, ar_q}, 16'h0);

    exp_ac = 16'hFFFF;
    for (int i = 0; i < 64; i++) begin
      bus_sel = 3'd7; pc_inr = 1'b1; dr_ld = 1'b1;
      #1 chk("R3 memory read", bus, exp_mem[i]);
      tick();
      bus_sel = 3'd7;
      #1 chk("R9 read unaffected by pc", bus, exp_mem[i]);
      chk("R4 dr from memory", dr_q, exp_mem[i]);
      ac_and = 1'b1; ar_inr = 1'b1; tick();
      exp_ac = exp_ac & exp_mem[i];
      chk("R6 ac and dr", ac_q, exp_ac);
    end

    h_ar = {4'h0, ar_q}; h_pc = {4'h0, pc_q};
    h_dr = dr_q; h_ac = ac_q; h_ir = ir_q; h_tr = tr_q;
    bus_sel = 3'd7; tick();
    chk("R5 ar hold", {4'h0, ar_q}, h_ar);
    chk("R5 pc hold", {4'h0, pc_q}, h_pc);
    chk("R5 dr hold", dr_q, h_dr);
    chk("R5 ac hold", ac_q, h_ac);
    chk("R5 ir hold", ir_q, h_ir);
    chk("R5 tr hold", tr_q, h_tr);

    bus_sel = 3'd3; pc_ld = 1'b1; pc_inr = 1'b1; tick();
    chk("R8 pc load over inc", {4'h0, pc_q}, 16'd133);
    bus_sel = 3'd3; pc_ld = 1'b1; pc_clr = 1'b1; tick();
    chk("R8 pc clear over load", {4'h0, pc_q}, 16'h0);
    bus_sel = 3'd3; ac_ld = 1'b1; ac_and = 1'b1; ac_inr = 1'b1; tick();
    chk("R8 ac load over and/inc", ac_q, 16'd133);
    ac_and = 1'b1; ac_inr = 1'b1; tick();
    chk("R8 ac and over inc", ac_q, 16'd133);
    bus_sel = 3'd3; ac_ld = 1'b1; ac_clr = 1'b1; tick();
    chk("R8 ac clear over load", ac_q, 16'h0);

    bus_sel = 3'd3; ir_ld = 1'b1; tick();
    chk("R4 ir load", ir_q, 16'd133);
    bus_sel = 3'd5;
    #1 chk("R2 ir on bus", bus, 16'd133);
    idle();
    ir_inr = 1'b1; tick();
    chk("R7 ir inc", ir_q, 16'd134);
    ir_clr = 1'b1; ir_inr = 1'b1; tick();
    chk("R8 ir clear over inc", ir_q, 16'h0);
    dr_inr = 1'b1; tick();
    chk("R7 dr inc", dr_q, 16'd134);
    bus_sel = 3'd3;
    #1 chk("R2 dr on bus", bus, 16'd134);
    idle();
    dr_clr = 1'b1; dr_ld = 1'b1; bus_sel = 3'd6; tick();
    chk("R8 dr clear over load", dr_q, 16'h0);

    summary();
    $finish;
  end
endmodule